// File: doc/BRIEF.md
# Interleaved Line Rasterizer Lane with Stipple

This block is one lane of a set of four line walkers that run side by side. Every lane receives the same precomputed line setup. That setup holds the start point, one direction bit per axis, a flag naming Y as the major axis, a signed decision term with its two increments, and the number of pixels. Each lane walks the whole line at the same rate. It raises a pixel write request only for pixels whose two low Y bits match the lane's own number, so together the four lanes cover every row exactly once.

A pixel the lane does not own costs one clock and produces no request. An owned pixel that is to be written is held on the output until the memory side accepts it. A 16-bit stipple word, stepped by a prescaler, gives each pixel a pattern bit. Depending on the stipple mode, that bit picks between the foreground and background value, or decides whether the pixel is written at all. An option treats the three pixels at each end of the line as if their pattern bit were set.

Top module: `lvg_lane`

## Requirements
- R1: `start` with a nonzero `count` while idle loads the setup, and `busy` is high from the next cycle. `start` with `count` equal to 0, or while `busy` is high, has no effect. While idle, `wr_valid` is low.
- R2: On each advance the major axis (Y when `y_major`=1, else X) steps by one. The minor axis also steps when the 16-bit signed decision term is at or above zero; the term then adds `inc_b`, otherwise it adds `inc_a`. A set direction bit (`x_neg`, `y_neg`) makes that axis count down.
- R3: The lane walks exactly `count` pixels, then drops `busy`.
- R4: A write request is raised only for pixels with `wr_y[1:0]` equal to the lane number `LANE_ID`.
- R5: A pixel that is not owned, or is owned but not to be written, advances in one clock. The number of busy cycles therefore equals `count` plus the cycles with `wr_valid` high and `wr_ready` low.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_x`, `wr_y` and `wr_fg` hold their values into the next cycle.
- R7: Pixel number k of the line (counted from 0 over all pixels, owned or not) takes bit `(k / P) mod 16` of `pattern`. P is 1, 2 or 4 for `presc_sel` 0, 1 or 2, and 3 also means 4.
- R8: With `stip_mode`=0 every owned pixel is written and `wr_fg` equals its effective pattern bit. With `stip_mode`=1 an owned pixel is written only if that bit is 1, and `wr_fg` is 1.
- R9: With `force_ends`=1, pixels k<3 and k>=`count`-3 have an effective pattern bit of 1.
- R10: With `stip_en`=0 the effective bit is always 1.
- R11: A synchronous active-high `rst` clears `busy` and `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load setup and begin a line |
| x0 | input | XW | Start X |
| y0 | input | YW | Start Y |
| x_neg | input | 1 | X steps downward |
| y_neg | input | 1 | Y steps downward |
| y_major | input | 1 | Y is the major axis |
| err0 | input | EW | Initial signed decision term |
| inc_a | input | EW | Decision increment when no minor step is taken |
| inc_b | input | EW | Decision increment when a minor step is taken |
| count | input | CW | Pixels in the line |
| pattern | input | PW | Stipple word |
| presc_sel | input | 2 | Pixels per pattern bit: 0=1, 1=2, else 4 |
| stip_mode | input | 1 | 0: pattern picks colour, 1: pattern masks the write |
| stip_en | input | 1 | Enable stipple |
| force_ends | input | 1 | Treat three pixels at each end as bit 1 |
| wr_ready | input | 1 | Memory side accepts the write |
| busy | output | 1 | Line in progress |
| wr_valid | output | 1 | Pixel write request |
| wr_x | output | XW | Request X |
| wr_y | output | YW | Request Y |
| wr_fg | output | 1 | 1 selects foreground, 0 background |

## Verification
The bench targets the stipple phase across lanes. A design that moved the pattern only on owned pixels would return wrong colours or masks for every pixel after the first unowned row. Lines that are long and steep, with every prescale choice, expose this. The bench also targets the end forcing on short lines, where head and tail overlap; an off-by-one there drops or adds a pixel next to the endpoints. Random back-pressure catches a lane that advances or changes its request while stalled. A cycle count per line catches a lane that stalls on pixels it does not own. A start pulse in the middle of a line, carrying different setup values, catches a lane that reloads while busy.

// File: rtl/lvg_pkg.sv
package lvg_pkg;
  typedef enum logic {
    STIP_COLOR = 1'b0,
    STIP_MASK  = 1'b1
  } stip_mode_e;

  // Highest prescale count value for a given select code.
  function automatic logic [1:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_limit = 2'd0;
      2'd1:    presc_limit = 2'd1;
      default: presc_limit = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/lvg_stepper.sv
module lvg_stepper #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int EW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic          x_neg,
  input  logic          y_neg,
  input  logic          y_major,
  input  logic [EW-1:0] err0,
  input  logic [EW-1:0] inc_a,
  input  logic [EW-1:0] inc_b,
  input  logic [CW-1:0] count,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output logic [CW-1:0] remain,
  output logic          busy
);
  logic          xn_q, yn_q, ym_q;
  logic [EW-1:0] err_q, ia_q, ib_q;
  logic          minor, step_x, step_y;

  // Decision term at or above zero takes the minor step too.
  assign minor  = ~err_q[EW-1];
  assign step_x = ~ym_q | minor;
  assign step_y =  ym_q | minor;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      cx     <= '0;
      cy     <= '0;
      err_q  <= '0;
      ia_q   <= '0;
      ib_q   <= '0;
      xn_q   <= 1'b0;
      yn_q   <= 1'b0;
      ym_q   <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= count;
      cx     <= x0;
      cy     <= y0;
      err_q  <= err0;
      ia_q   <= inc_a;
      ib_q   <= inc_b;
      xn_q   <= x_neg;
      yn_q   <= y_neg;
      ym_q   <= y_major;
    end else if (busy && adv) begin
      remain <= remain - 1'b1;
      if (remain == CW'(1)) busy <= 1'b0;
      if (step_x) cx <= xn_q ? cx - 1'b1 : cx + 1'b1;
      if (step_y) cy <= yn_q ? cy - 1'b1 : cy + 1'b1;
      err_q <= minor ? err_q + ib_q : err_q + ia_q;
    end
  end

  p_busy_stays_r3: assert property (@(posedge clk) disable iff (rst)
    busy && !adv |=> busy);

  p_major_moves_r2: assert property (@(posedge clk) disable iff (rst)
    busy && adv && remain > CW'(1) |=>
      (ym_q ? (cy != $past(cy)) : (cx != $past(cx))));
endmodule

// File: rtl/lvg_stipple.sv
module lvg_stipple
  import lvg_pkg::*;
#(
  parameter int PW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [PW-1:0] pattern,
  input  logic [1:0]    presc_sel,
  input  logic          mode_in,
  input  logic          stip_en,
  input  logic          force_ends,
  input  logic [CW-1:0] remain,
  input  logic          owned,
  output logic          need_wr,
  output logic          fg
);
  logic [PW-1:0] pat_q;
  logic [1:0]    lim_q, pre_cnt, head_cnt;
  logic          en_q, fe_q;
  stip_mode_e    mode_q;
  logic          forced, bit_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q    <= '0;
      lim_q    <= '0;
      pre_cnt  <= '0;
      head_cnt <= '0;
      en_q     <= 1'b0;
      fe_q     <= 1'b0;
      mode_q   <= STIP_COLOR;
    end else if (load) begin
      pat_q    <= pattern;
      lim_q    <= presc_limit(presc_sel);
      pre_cnt  <= '0;
      head_cnt <= '0;
      en_q     <= stip_en;
      fe_q     <= force_ends;
      mode_q   <= stip_mode_e'(mode_in);
    end else if (adv) begin
      // Every pixel of the line moves the pattern, owned or not.
      if (pre_cnt == lim_q) begin
        pre_cnt <= '0;
        pat_q   <= {pat_q[0], pat_q[PW-1:1]};
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (head_cnt != 2'd3) head_cnt <= head_cnt + 1'b1;
    end
  end

  assign forced  = fe_q && (head_cnt != 2'd3 || remain <= CW'(3));
  assign bit_eff = ~en_q | pat_q[0] | forced;

  always_comb begin
    if (mode_q == STIP_MASK) begin
      need_wr = owned & bit_eff;
      fg      = 1'b1;
    end else begin
      need_wr = owned;
      fg      = bit_eff;
    end
  end
endmodule

// File: rtl/lvg_lane.sv
module lvg_lane #(
  parameter int LANE_ID = 1,
  parameter int XW      = 12,
  parameter int YW      = 12,
  parameter int EW      = 16,
  parameter int CW      = 12,
  parameter int PW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic          x_neg,
  input  logic          y_neg,
  input  logic          y_major,
  input  logic [EW-1:0] err0,
  input  logic [EW-1:0] inc_a,
  input  logic [EW-1:0] inc_b,
  input  logic [CW-1:0] count,
  input  logic [PW-1:0] pattern,
  input  logic [1:0]    presc_sel,
  input  logic          stip_mode,
  input  logic          stip_en,
  input  logic          force_ends,
  input  logic          wr_ready,
  output logic          busy,
  output logic          wr_valid,
  output logic [XW-1:0] wr_x,
  output logic [YW-1:0] wr_y,
  output logic          wr_fg
);
  localparam logic [1:0] LANE = 2'(LANE_ID);

  logic          load, adv, owned, need_wr;
  logic [CW-1:0] remain;

  assign load     = start && !busy && (count != '0);
  assign owned    = (wr_y[1:0] == LANE);
  assign wr_valid = busy && need_wr;
  assign adv      = busy && (!need_wr || wr_ready);

  lvg_stepper #(.XW(XW), .YW(YW), .EW(EW), .CW(CW)) u_step (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .x0(x0), .y0(y0), .x_neg(x_neg), .y_neg(y_neg), .y_major(y_major),
    .err0(err0), .inc_a(inc_a), .inc_b(inc_b), .count(count),
    .cx(wr_x), .cy(wr_y), .remain(remain), .busy(busy)
  );

  lvg_stipple #(.PW(PW), .CW(CW)) u_stip (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .pattern(pattern), .presc_sel(presc_sel), .mode_in(stip_mode),
    .stip_en(stip_en), .force_ends(force_ends), .remain(remain),
    .owned(owned), .need_wr(need_wr), .fg(wr_fg)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_valid);

  p_own_rows_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_y[1:0] == LANE);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=>
      wr_valid && $stable(wr_x) && $stable(wr_y) && $stable(wr_fg));
endmodule

// File: tb/lvg_lane_tb.sv
`timescale 1ns/1ps
module lvg_lane_tb;
  localparam int LANE = 1;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0;
  logic [11:0] x0 = '0, y0 = '0, count = '0;
  logic        x_neg = 0, y_neg = 0, y_major = 0;
  logic [15:0] err0 = '0, inc_a = '0, inc_b = '0, pattern = '0;
  logic [1:0]  presc_sel = '0;
  logic        stip_mode = 0, stip_en = 0, force_ends = 0, rdy = 0;
  logic        busy, wr_valid, wr_fg;
  logic [11:0] wr_x, wr_y;

  int total = 0, bad = 0;
  logic [11:0] ex_x [0:511];
  logic [11:0] ex_y [0:511];
  logic        ex_f [0:511];
  int          ex_n;

  lvg_lane #(.LANE_ID(LANE)) u_dut (
    .clk(clk), .rst(rst), .start(start), .x0(x0), .y0(y0),
    .x_neg(x_neg), .y_neg(y_neg), .y_major(y_major),
    .err0(err0), .inc_a(inc_a), .inc_b(inc_b), .count(count),
    .pattern(pattern), .presc_sel(presc_sel), .stip_mode(stip_mode),
    .stip_en(stip_en), .force_ends(force_ends), .wr_ready(rdy),
    .busy(busy), .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y), .wr_fg(wr_fg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected write list from R2, R4, R7-R10.
  task automatic gen_expect();
    logic [11:0] x = x0, y = y0;
    logic signed [15:0] e = err0;
    int p = (presc_sel == 0) ? 1 : (presc_sel == 1) ? 2 : 4;
    ex_n = 0;
    for (int k = 0; k < int'(count); k++) begin
      bit pb = pattern[(k / p) % 16];
      bit forced = force_ends && (k < 3 || k >= int'(count) - 3);
      bit b = !stip_en || pb || forced;
      if (y[1:0] == 2'(LANE)) begin
        if (!stip_mode) begin
          ex_x[ex_n] = x; ex_y[ex_n] = y; ex_f[ex_n] = b; ex_n++;
        end else if (b) begin
          ex_x[ex_n] = x; ex_y[ex_n] = y; ex_f[ex_n] = 1'b1; ex_n++;
        end
      end
      begin
        bit mn = (e >= 0);
        if (!y_major || mn) x = x_neg ? x - 1 : x + 1;
        if (y_major || mn)  y = y_neg ? y - 1 : y + 1;
        e = mn ? e + signed'(inc_b) : e + signed'(inc_a);
      end
    end
  endtask

  task automatic setup_line(input int dmaj, input int dmin, input bit ym);
    y_major = ym;
    x_neg = $urandom % 2; y_neg = $urandom % 2;
    x0 = 12'($urandom); y0 = 12'($urandom);
    err0  = 16'(2 * dmin - dmaj);
    inc_a = 16'(2 * dmin);
    inc_b = 16'(2 * (dmin - dmaj));
    count = 12'(dmaj + 1);
  endtask

  task automatic run_vec(input bit poke);
    int wi = 0, bc = 0, st = 0, it = 0;
    bit hold = 0;
    logic [11:0] hx, hy;
    logic hf;
    int cnt = int'(count);
    gen_expect();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    while (busy && it < 20000) begin
      rdy = ($urandom % 4) != 0;
      if (poke && it == 2) begin
        start = 1'b1; x0 = 12'($urandom); count = 12'd5; pattern = ~pattern;
      end else start = 1'b0;
      #1;
      if (hold)
        chk(wr_valid && wr_x == hx && wr_y == hy && wr_fg == hf,
            "R6 stall hold", int'(wr_x), int'(hx));
      bc++;
      hold = 0;
      if (wr_valid) begin
        if (rdy) begin
          if (wi >= ex_n) chk(0, "R4 extra write", wi, ex_n);
          else chk(wr_x == ex_x[wi] && wr_y == ex_y[wi] && wr_fg == ex_f[wi],
                   "R2 R7 R8 pixel", int'({wr_fg, wr_y, wr_x}),
                   int'({ex_f[wi], ex_y[wi], ex_x[wi]}));
          wi++;
        end else begin
          st++; hold = 1; hx = wr_x; hy = wr_y; hf = wr_fg;
        end
      end
      @(negedge clk);
      it++;
    end
    start = 1'b0;
    if (it >= 20000) chk(0, "R3 watchdog", it, cnt);
    chk(wi == ex_n, "R3 R4 write count", wi, ex_n);
    chk(bc == cnt + st, "R5 busy cycles", bc, cnt + st);
  endtask

  initial begin
    #(1_000_000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && wr_valid === 1'b0, "R11 reset state", busy, 0);

    // R1: zero count does nothing
    count = '0; start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(busy === 1'b0, "R1 zero count", busy, 0);

    // R10: no stipple, shallow line
    stip_en = 0; setup_line(40, 13, 0); run_vec(0);
    // R4 R5: horizontal line on a row this lane does not own
    setup_line(30, 0, 0); y0 = 12'h102; run_vec(0);
    // R9: mask mode, empty pattern, forced ends on a steep line
    stip_en = 1; stip_mode = 1; force_ends = 1; pattern = '0;
    setup_line(50, 7, 1); run_vec(0);
    // R9: short line where head and tail overlap
    setup_line(3, 1, 1); run_vec(0);
    // R7: each prescale on a steep colour-mode line
    force_ends = 0; stip_mode = 0;
    for (int s = 0; s < 4; s++) begin
      presc_sel = 2'(s); pattern = 16'hB38D;
      setup_line(90, 20, 1); run_vec(0);
    end
    // R1: start while busy is ignored
    pattern = 16'h0F31; presc_sel = 1; setup_line(60, 60, 1); run_vec(1);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      int dmaj = $urandom % 120;
      stip_en = $urandom % 2; stip_mode = $urandom % 2;
      force_ends = $urandom % 2; presc_sel = 2'($urandom);
      pattern = 16'($urandom);
      setup_line(dmaj, $urandom % (dmaj + 1), $urandom % 2);
      run_vec(n % 7 == 3 && dmaj > 10);
    end

    @(negedge clk);
    chk(wr_valid === 1'b0, "R1 idle quiet", wr_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule